// File: doc/BRIEF.md
# Page Translation Buffer with Write Protection

This block is a small, fully associative translation cache. It sits between an address source and memory and turns virtual page numbers into physical frame numbers. Every lookup compares the page number against all stored tags at once. On a match the block returns the physical address, which is the stored frame number joined to the untouched page offset. In the same cycle it checks whether a write is aimed at a read-only page. On a miss it raises a flag, so an outside agent can fetch the mapping and load it through the fill port.

Each entry holds a valid bit, a page tag, a frame number and a writable bit. A fill for a page already held overwrites that entry in place. A fill for a new page takes the lowest-numbered empty slot. When every slot is full, a round-robin pointer chooses the slot to evict. A flush input empties the whole buffer at a context switch.

Top module: `page_xlat_buf`

## Requirements
- R1: After reset all three response flags and the physical address are 0, and every entry is empty, so the first lookup of any page misses.
- R2: A lookup request of a page held in the buffer gives, one cycle later, rsp_hit=1, rsp_miss=0 and rsp_pa equal to the stored frame number in the upper bits and the request's 12-bit offset passed through unchanged in the lower bits.
- R3: A lookup of a page not held gives, one cycle later, rsp_miss=1, rsp_hit=0, rsp_fault=0 and rsp_pa=0. Hit and miss are never both 1.
- R4: In the cycle after a cycle with no lookup request, rsp_hit, rsp_miss and rsp_fault are all 0.
- R5: fill_writable=1 marks an entry read-write and 0 marks it read-only. A write lookup (lk_wr=1) that hits a read-only entry sets rsp_fault=1 along with rsp_hit=1. A read lookup of any entry, or a write lookup of a read-write entry, leaves rsp_fault=0.
- R6: rsp_fault is only ever 1 together with rsp_hit. A missing write raises no fault.
- R7: A fill for a page already held replaces that entry's frame and writable bit. It takes no new slot and does not move the round-robin pointer.
- R8: A fill for a new page, while any entry is empty, goes to the lowest-numbered empty entry, so ENTRIES distinct fills after a flush all stay resident.
- R9: A fill for a new page when no entry is empty evicts the entry at the round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping around, on each such eviction.
- R10: Flush empties every entry and returns the round-robin pointer to entry 0. A fill in the same cycle as a flush is discarded.
- R11: A lookup in the same cycle as a fill or flush sees the buffer contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_wr | input | 1 | 1 = write access, 0 = read access |
| fill_en | input | 1 | Load a mapping |
| fill_vpn | input | 20 | Page number of the mapping |
| fill_pfn | input | 20 | Frame number of the mapping |
| fill_writable | input | 1 | 1 = read-write, 0 = read-only |
| flush | input | 1 | Empty the whole buffer |
| rsp_hit | output | 1 | Lookup hit, one cycle after the request |
| rsp_miss | output | 1 | Lookup miss, one cycle after the request |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_pa | output | 32 | Physical address on a hit, else 0 |

## Verification
The bench refills a page that is already resident and then looks it up. A design that allocated a second slot would return a merged or stale frame, or a stale protection bit. It fills the buffer past capacity twice, with an in-place update in between. This exposes a pointer that starts at the wrong slot, skips slots, or advances on an update. It issues a flush in the same cycle as a fill, and a fill in the same cycle as a lookup. A design that let the fill win would then hit where it must miss. It also drives writes to a read-only page, to a read-write page and to a missing page. A protection check wired to the wrong polarity, or one not gated by the hit, would flag the wrong case.

// File: rtl/page_xlat_buf.sv
module page_xlat_buf #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_req,
  input  logic [VA_W-1:0]        lk_va,
  input  logic                   lk_wr,
  input  logic                   fill_en,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   fill_writable,
  input  logic                   flush,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_fault,
  output logic [PFN_W+OFF_W-1:0] rsp_pa
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] wok_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_wok;
  logic               lk_any, fl_any, free_any;
  logic [IDX_W-1:0]   fl_idx, free_idx, victim;
  logic               do_fill, evict;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];
  assign lk_off = lk_va[OFF_W-1:0];

  always_comb begin
    hit_pfn  = '0;
    hit_wok  = 1'b0;
    fl_idx   = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = valid_q[i] && (tag_q[i] == lk_vpn);
      fl_match[i] = valid_q[i] && (tag_q[i] == fill_vpn);
      if (lk_match[i]) begin
        hit_pfn = hit_pfn | pfn_q[i];
        hit_wok = hit_wok | wok_q[i];
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fl_match[i]) fl_idx = IDX_W'(i);
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign lk_any   = |lk_match;
  assign fl_any   = |fl_match;
  assign free_any = ~&valid_q;
  assign victim   = fl_any ? fl_idx : (free_any ? free_idx : rr_q);
  assign do_fill  = fill_en && !flush;
  assign evict    = do_fill && !fl_any && !free_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (do_fill) begin
      valid_q[victim] <= 1'b1;
      if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[victim] <= fill_vpn;
      pfn_q[victim] <= fill_pfn;
      wok_q[victim] <= fill_writable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_hit   <= lk_req && lk_any;
      rsp_miss  <= lk_req && !lk_any;
      rsp_fault <= lk_req && lk_any && lk_wr && !hit_wok;
      rsp_pa    <= (lk_req && lk_any) ? {hit_pfn, lk_off} : PA_W'(0);
    end
  end
endmodule

// File: rtl/page_xlat_buf_chk.sv
module page_xlat_buf_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic            flush,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_pa
);
  assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  assert_miss_pa_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0) && !rsp_fault);

  assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !(rsp_hit || rsp_miss || rsp_fault));

  assert_req_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_hit || rsp_miss));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_req |=> rsp_miss);
endmodule

bind page_xlat_buf page_xlat_buf_chk #(.PA_W(PFN_W + OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .flush(flush),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/page_xlat_buf_tb_top.sv
`timescale 1ns/1ps
module page_xlat_buf_tb_top;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_req = 0, lk_wr = 0, fill_en = 0, fill_writable = 0, flush = 0;
  logic [31:0] lk_va = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic        rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_pa;

  int checks = 0, failures = 0;
  logic g_hit, g_miss, g_fault;
  logic [31:0] g_pa;

  always #2.5 clk = ~clk;

  page_xlat_buf dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_wr(lk_wr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_writable(fill_writable), .flush(flush),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] f, input logic w);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pfn = f; fill_writable = w;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic lookup(input logic [19:0] v, input logic [11:0] off, input logic wr);
    @(negedge clk);
    lk_req = 1; lk_va = {v, off}; lk_wr = wr;
    @(negedge clk);
    lk_req = 0;
    g_hit = rsp_hit; g_miss = rsp_miss; g_fault = rsp_fault; g_pa = rsp_pa;
  endtask

  task automatic expect_hit(input string req, input logic [19:0] v, input logic [19:0] f,
                            input logic [11:0] off, input logic wr, input logic flt);
    lookup(v, off, wr);
    check(req, {g_hit, g_miss, g_fault}, {1'b1, 1'b0, flt});
    check(req, g_pa, {f, off});
  endtask

  task automatic expect_miss(input string req, input logic [19:0] v, input logic wr);
    lookup(v, 12'h3c5, wr);
    check(req, {g_hit, g_miss, g_fault}, 3'b010);
    check(req, g_pa, 32'h0);
  endtask

  task automatic t_reset();
    check("R1 reset flags", {rsp_hit, rsp_miss, rsp_fault}, 3'b000);
    check("R1 reset pa", rsp_pa, 32'h0);
    expect_miss("R1 R3 empty after reset", 20'h00005, 1'b0);
  endtask

  task automatic t_hit_idle();
    do_fill(20'h12345, 20'hABCDE, 1'b1);
    expect_hit("R2 read hit", 20'h12345, 20'hABCDE, 12'h678, 1'b0, 1'b0);
    expect_hit("R2 offset passthrough", 20'h12345, 20'hABCDE, 12'hFFF, 1'b0, 1'b0);
    expect_hit("R5 write to read-write", 20'h12345, 20'hABCDE, 12'h001, 1'b1, 1'b0);
    @(negedge clk);
    check("R4 idle cycle quiet", {rsp_hit, rsp_miss, rsp_fault}, 3'b000);
  endtask

  task automatic t_protect();
    do_fill(20'h22222, 20'h11111, 1'b0);
    expect_hit("R5 write to read-only faults", 20'h22222, 20'h11111, 12'h010, 1'b1, 1'b1);
    expect_hit("R5 read of read-only ok", 20'h22222, 20'h11111, 12'h010, 1'b0, 1'b0);
    expect_miss("R6 missing write no fault", 20'h99999, 1'b1);
  endtask

  task automatic t_update();
    do_fill(20'h12345, 20'h0F0F0, 1'b0);
    expect_hit("R7 in-place new frame", 20'h12345, 20'h0F0F0, 12'h234, 1'b0, 1'b0);
    expect_hit("R7 in-place new protection", 20'h12345, 20'h0F0F0, 12'h234, 1'b1, 1'b1);
  endtask

  task automatic t_concurrent();
    @(negedge clk);
    fill_en = 1; fill_vpn = 20'h33333; fill_pfn = 20'h44444; fill_writable = 1;
    lk_req = 1; lk_va = {20'h33333, 12'h0AA}; lk_wr = 0;
    @(negedge clk);
    fill_en = 0; lk_req = 0;
    check("R11 lookup sees pre-fill state", {rsp_hit, rsp_miss}, 2'b01);
    expect_hit("R11 fill visible afterwards", 20'h33333, 20'h44444, 12'h0AA, 1'b0, 1'b0);
  endtask

  task automatic t_evict();
    do_flush();
    expect_miss("R10 flush empties", 20'h33333, 1'b0);
    for (int i = 0; i < N; i++) do_fill(20'h40000 + 20'(i), 20'h50000 + 20'(i), 1'b1);
    for (int i = 0; i < N; i++)
      expect_hit("R8 all slots resident", 20'h40000 + 20'(i), 20'h50000 + 20'(i), 12'h100, 1'b0, 1'b0);
    do_fill(20'h40008, 20'h50008, 1'b1);
    expect_miss("R9 first eviction takes slot 0", 20'h40000, 1'b0);
    expect_hit("R9 slot 1 kept", 20'h40001, 20'h50001, 12'h100, 1'b0, 1'b0);
    do_fill(20'h40009, 20'h50009, 1'b1);
    expect_miss("R9 second eviction takes slot 1", 20'h40001, 1'b0);
    do_fill(20'h40005, 20'h5AAAA, 1'b1);
    expect_hit("R7 update when full", 20'h40005, 20'h5AAAA, 12'h100, 1'b0, 1'b0);
    do_fill(20'h4000A, 20'h5000A, 1'b1);
    expect_miss("R7 R9 update kept pointer", 20'h40002, 1'b0);
    expect_hit("R9 slot 3 kept", 20'h40003, 20'h50003, 12'h100, 1'b0, 1'b0);
    expect_hit("R9 newest resident", 20'h4000A, 20'h5000A, 12'h100, 1'b0, 1'b0);
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush = 1; fill_en = 1; fill_vpn = 20'h77777; fill_pfn = 20'h12121; fill_writable = 1;
    @(negedge clk);
    flush = 0; fill_en = 0;
    expect_miss("R10 fill dropped during flush", 20'h77777, 1'b0);
    expect_miss("R10 old entry gone", 20'h4000A, 1'b0);
    for (int i = 0; i < N; i++) do_fill(20'h60000 + 20'(i), 20'h70000 + 20'(i), 1'b1);
    do_fill(20'h60008, 20'h70008, 1'b1);
    expect_miss("R10 pointer back at slot 0", 20'h60000, 1'b0);
    expect_hit("R10 slot 1 kept", 20'h60001, 20'h70001, 12'h100, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hit_idle();
    t_protect();
    t_update();
    t_concurrent();
    t_evict();
    t_flush_fill();
    finish_run();
  end
endmodule